// File: doc/BRIEF.md
# Control Endpoint Stage Tracker

This block follows a control transfer on the default endpoint through its stages. A decoded SETUP packet gives two facts: the direction bit and the requested length. From these the block picks the data stage: host-to-device (OUT, receive) or device-to-host (IN, transmit). If the length is zero, the block goes straight to the status stage. Packet-done events move the data stage forward. A transmit stage ends with a completion wait, and any state can be stalled.

The current stage is output as a 3-bit code. Two single-cycle strobes go to the surrounding endpoint logic:
- `data_go` starts the data stage.
- `status_go` starts the status handshake.

A new SETUP always wins over an unfinished stage, and a stall request wins over everything. The stall is left only when the next SETUP arrives. The block needs no separate clear.

State codes: IDLE_SETUP = 1, DATA_IN = 2, DATA_OUT = 3, IN_DRAIN = 4, HALTED = 5.

Transitions:
- **accept_nodata**: IDLE_SETUP to IDLE_SETUP.
- **accept_in**: any state to DATA_IN.
- **accept_out**: any state to DATA_OUT.
- **last_sent**: DATA_IN to IN_DRAIN.
- **drained**: IN_DRAIN to IDLE_SETUP.
- **out_done**: DATA_OUT to IDLE_SETUP.
- **halt**: any state to HALTED.
- **unhalt**: HALTED to IDLE_SETUP, DATA_IN or DATA_OUT, through a SETUP.

Top module: `ctl_ep_stage_fsm`

## Requirements
- R1: After reset, `state_o` is 1 (IDLE_SETUP) and both strobes are low. The codes are 1 IDLE_SETUP, 2 DATA_IN, 3 DATA_OUT, 4 IN_DRAIN and 5 HALTED.
- R2: A SETUP with `setup_len` = 0 leaves the state at IDLE_SETUP. `status_go` pulses for exactly one cycle, and `data_go` stays low.
- R3: A SETUP with `setup_len` > 0 and `setup_dir_in` = 1 (bit 7 of the request type) moves the state to DATA_IN and pulses `data_go` once.
- R4: A SETUP with `setup_len` > 0 and `setup_dir_in` = 0 moves the state to DATA_OUT and pulses `data_go` once.
- R5: In DATA_IN, a `pkt_done` without `pkt_last` keeps the state. A `pkt_done` with `pkt_last` moves the state to IN_DRAIN with no strobe.
- R6: IN_DRAIN holds until `xfer_cmpl`. Other events are ignored. `xfer_cmpl` returns the state to IDLE_SETUP and pulses `status_go`.
- R7: In DATA_OUT, a packet shorter than MAX_PKT bytes (64 by default) returns the state to IDLE_SETUP and pulses `status_go`.
- R8: In DATA_OUT, full packets keep the state until the bytes received reach `setup_len`. That packet returns the state to IDLE_SETUP and pulses `status_go`.
- R9: A SETUP in DATA_IN, DATA_OUT or IN_DRAIN abandons that stage and is decoded as in R2 to R4. The byte count restarts from the new length.
- R10: `stall_req` moves any state to HALTED and takes priority over a SETUP in the same cycle.
- R11: HALTED ignores `pkt_done`, `pkt_last` and `xfer_cmpl`. The next SETUP leaves it, decoded as in R2 to R4.
- R12: IDLE_SETUP ignores `pkt_done`, `pkt_last` and `xfer_cmpl`: the state stays and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| setup_valid | input | 1 | A SETUP packet has been received this cycle |
| setup_dir_in | input | 1 | Direction bit of the request type (bit 7): 1 = device-to-host |
| setup_len | input | LEN_W | Requested data length of the SETUP |
| pkt_done | input | 1 | A data packet finished this cycle |
| pkt_last | input | 1 | With `pkt_done` in DATA_IN: the final IN packet |
| pkt_bytes | input | PKT_W | Byte count of the finished OUT packet |
| xfer_cmpl | input | 1 | Transfer completion interrupt |
| stall_req | input | 1 | Request to stall the endpoint |
| state_o | output | 3 | Current stage code |
| data_go | output | 1 | One-cycle strobe: data stage starts |
| status_go | output | 1 | One-cycle strobe: status stage starts |

## Verification
All inputs are registered on one clock edge. A wrong transition therefore shows on `state_o` one cycle after the event that caused it. The same cycle shows a strobe that is missing or extra.

A fault in the OUT byte count stays hidden while full packets arrive. It shows only on the packet that should end the stage. The stage then either ends one packet early, or stays in DATA_OUT with no `status_go`.

A stuck IN_DRAIN or HALTED shows as a state that ignores its exit event.

// File: rtl/ep0_stage_pkg.sv
package ep0_stage_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_SETUP = 3'd1,
        ST_DATA_IN    = 3'd2,
        ST_DATA_OUT   = 3'd3,
        ST_IN_DRAIN   = 3'd4,
        ST_HALTED     = 3'd5
    } ep0_stage_e;

endpackage

// File: rtl/ep0_setup_decode.sv
module ep0_setup_decode #(
    parameter int LEN_W = 16
) (
    input  logic             dir_bit,
    input  logic [LEN_W-1:0] req_len,
    output logic             has_data,
    output logic             to_host
);
    always_comb begin
        has_data = (req_len != '0);
        to_host  = dir_bit;
    end
endmodule

// File: rtl/ep0_out_counter.sv
module ep0_out_counter #(
    parameter int LEN_W   = 16,
    parameter int MAX_PKT = 64,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             take,
    input  logic [PKT_W-1:0] take_bytes,
    output logic             finish
);
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] bytes_ext;

    always_comb begin
        bytes_ext = LEN_W'(take_bytes);
        finish    = (take_bytes < PKT_W'(MAX_PKT)) || (bytes_ext >= left_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_len;
        end else if (take) begin
            left_q <= finish ? '0 : (left_q - bytes_ext);
        end
    end

    // Remaining count never grows except on a fresh load (R8)
    assert_left_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> left_q <= $past(left_q))
        else $error("remaining OUT count grew without a load");
endmodule

// File: rtl/ctl_ep_stage_fsm.sv
module ctl_ep_stage_fsm
    import ep0_stage_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_PKT = 64,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic             setup_dir_in,
    input  logic [LEN_W-1:0] setup_len,
    input  logic             pkt_done,
    input  logic             pkt_last,
    input  logic [PKT_W-1:0] pkt_bytes,
    input  logic             xfer_cmpl,
    input  logic             stall_req,
    output logic [2:0]       state_o,
    output logic             data_go,
    output logic             status_go
);
    ep0_stage_e state, next_state;
    logic next_data_go, next_status_go;
    logic has_data, to_host, out_finish;
    logic accept_setup, out_take;

    ep0_setup_decode #(.LEN_W(LEN_W)) u_decode (
        .dir_bit  (setup_dir_in),
        .req_len  (setup_len),
        .has_data (has_data),
        .to_host  (to_host)
    );

    always_comb begin
        accept_setup = setup_valid && !stall_req;
        out_take     = pkt_done && (state == ST_DATA_OUT) && !setup_valid && !stall_req;
    end

    ep0_out_counter #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept_setup),
        .load_len   (setup_len),
        .take       (out_take),
        .take_bytes (pkt_bytes),
        .finish     (out_finish)
    );

    always_comb begin
        next_state     = state;
        next_data_go   = 1'b0;
        next_status_go = 1'b0;
        if (stall_req) begin
            next_state = ST_HALTED;
        end else if (setup_valid) begin
            if (has_data) begin
                next_state   = to_host ? ST_DATA_IN : ST_DATA_OUT;
                next_data_go = 1'b1;
            end else begin
                next_state     = ST_IDLE_SETUP;
                next_status_go = 1'b1;
            end
        end else begin
            unique case (state)
                ST_DATA_IN: begin
                    if (pkt_done && pkt_last) next_state = ST_IN_DRAIN;
                end
                ST_IN_DRAIN: begin
                    if (xfer_cmpl) begin
                        next_state     = ST_IDLE_SETUP;
                        next_status_go = 1'b1;
                    end
                end
                ST_DATA_OUT: begin
                    if (pkt_done && out_finish) begin
                        next_state     = ST_IDLE_SETUP;
                        next_status_go = 1'b1;
                    end
                end
                ST_IDLE_SETUP, ST_HALTED: next_state = state;
                default: next_state = ST_IDLE_SETUP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE_SETUP;
        else        state <= next_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_go   <= 1'b0;
            status_go <= 1'b0;
        end else begin
            data_go   <= next_data_go;
            status_go <= next_status_go;
        end
    end

    assign state_o = state;

    assert_stall_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> state == ST_HALTED)
        else $error("stall request did not halt");

    assert_drain_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN_DRAIN && !xfer_cmpl && !setup_valid && !stall_req) |=> state == ST_IN_DRAIN)
        else $error("IN drain left without completion");

    assert_drain_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN_DRAIN && xfer_cmpl && !setup_valid && !stall_req) |=> (status_go && state == ST_IDLE_SETUP))
        else $error("completion in IN drain mishandled");

    assert_data_go_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> (state == ST_DATA_IN || state == ST_DATA_OUT))
        else $error("data strobe outside a data stage");

    assert_status_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_go |-> state == ST_IDLE_SETUP)
        else $error("status strobe outside idle stage");

    assert_halt_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && setup_valid && !stall_req) |=> state != ST_HALTED)
        else $error("SETUP did not clear halt");

    assert_strobes_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_go && status_go))
        else $error("both strobes at once");
endmodule

// File: tb/sim_ctl_ep_stage_fsm.sv
module sim_ctl_ep_stage_fsm;
    localparam int LEN_W   = 16;
    localparam int MAX_PKT = 64;
    localparam int PKT_W   = $clog2(MAX_PKT + 1);

    localparam logic [2:0] S_IDLE  = 3'd1;
    localparam logic [2:0] S_IN    = 3'd2;
    localparam logic [2:0] S_OUT   = 3'd3;
    localparam logic [2:0] S_DRAIN = 3'd4;
    localparam logic [2:0] S_HALT  = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_valid = 1'b0, setup_dir_in = 1'b0;
    logic [LEN_W-1:0] setup_len = '0;
    logic pkt_done = 1'b0, pkt_last = 1'b0, xfer_cmpl = 1'b0, stall_req = 1'b0;
    logic [PKT_W-1:0] pkt_bytes = '0;
    logic [2:0] state_o;
    logic data_go, status_go;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic       dg;
        logic       sg;
        string      tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    ctl_ep_stage_fsm #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_dir_in(setup_dir_in), .setup_len(setup_len),
        .pkt_done(pkt_done), .pkt_last(pkt_last), .pkt_bytes(pkt_bytes),
        .xfer_cmpl(xfer_cmpl), .stall_req(stall_req),
        .state_o(state_o), .data_go(data_go), .status_go(status_go)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic sv, input logic dir, input int len,
                        input logic pd, input logic pl, input int pb,
                        input logic xc, input logic st,
                        input logic [2:0] e_st, input logic e_dg, input logic e_sg,
                        input string tag);
        exp_t e;
        @(negedge clk);
        setup_valid  = sv;
        setup_dir_in = dir;
        setup_len    = LEN_W'(len);
        pkt_done     = pd;
        pkt_last     = pl;
        pkt_bytes    = PKT_W'(pb);
        xfer_cmpl    = xc;
        stall_req    = st;
        e.st = e_st; e.dg = e_dg; e.sg = e_sg; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input logic [2:0] e_st, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, e_st, 0, 0, tag);
    endtask

    // Monitor: compares outputs after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (state_o !== e.st || data_go !== e.dg || status_go !== e.sg) begin
                    fails++;
                    $display("FAIL %s: state=%0d data_go=%0b status_go=%0b, expected state=%0d data_go=%0b status_go=%0b",
                             e.tag, state_o, data_go, status_go, e.st, e.dg, e.sg);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (state_o !== S_IDLE || data_go !== 1'b0 || status_go !== 1'b0) begin
            fails++;
            $display("FAIL R1: state=%0d dg=%0b sg=%0b, expected state=1 dg=0 sg=0",
                     state_o, data_go, status_go);
        end
        idle(S_IDLE, "R1 idle");
        // R12: events ignored in idle
        step(0, 0, 0, 1, 1, 64, 1, 0, S_IDLE, 0, 0, "R12");
        // R2: no-data SETUP
        step(1, 1, 0, 0, 0, 0, 0, 0, S_IDLE, 0, 1, "R2 strobe");
        idle(S_IDLE, "R2 single pulse");
        // R3/R5/R6: IN transfer
        step(1, 1, 10, 0, 0, 0, 0, 0, S_IN, 1, 0, "R3");
        step(0, 0, 0, 1, 0, 0, 0, 0, S_IN, 0, 0, "R5 not last");
        step(0, 0, 0, 1, 1, 0, 0, 0, S_DRAIN, 0, 0, "R5 last");
        idle(S_DRAIN, "R6 wait");
        step(0, 0, 0, 1, 1, 0, 0, 0, S_DRAIN, 0, 0, "R6 ignores pkt");
        step(0, 0, 0, 0, 0, 0, 1, 0, S_IDLE, 0, 1, "R6 cmpl");
        // R4/R8: OUT reaching length with full packets
        step(1, 0, 128, 0, 0, 0, 0, 0, S_OUT, 1, 0, "R4");
        step(0, 0, 0, 1, 0, 64, 0, 0, S_OUT, 0, 0, "R8 partial");
        step(0, 0, 0, 1, 0, 64, 0, 0, S_IDLE, 0, 1, "R8 reached");
        // R7: short packet
        step(1, 0, 200, 0, 0, 0, 0, 0, S_OUT, 1, 0, "R4 second");
        step(0, 0, 0, 1, 0, 10, 0, 0, S_IDLE, 0, 1, "R7 short");
        // R9: aborts
        step(1, 0, 200, 0, 0, 0, 0, 0, S_OUT, 1, 0, "R9 start out");
        step(0, 0, 0, 1, 0, 64, 0, 0, S_OUT, 0, 0, "R9 partial");
        step(1, 1, 4, 0, 0, 0, 0, 0, S_IN, 1, 0, "R9 out->in");
        step(1, 1, 0, 0, 0, 0, 0, 0, S_IDLE, 0, 1, "R9 in->nodata");
        step(1, 1, 64, 0, 0, 0, 0, 0, S_IN, 1, 0, "R9 in");
        step(0, 0, 0, 1, 1, 0, 0, 0, S_DRAIN, 0, 0, "R9 drain");
        step(1, 0, 128, 0, 0, 0, 0, 0, S_OUT, 1, 0, "R9 drain->out");
        step(0, 0, 0, 1, 0, 64, 0, 0, S_OUT, 0, 0, "R9 fresh count");
        // R10/R11: stall
        step(0, 0, 0, 0, 0, 0, 0, 1, S_HALT, 0, 0, "R10 from out");
        step(0, 0, 0, 1, 1, 5, 1, 0, S_HALT, 0, 0, "R11 ignores");
        step(1, 0, 0, 0, 0, 0, 0, 0, S_IDLE, 0, 1, "R11 setup clears");
        step(1, 1, 8, 0, 0, 0, 0, 1, S_HALT, 0, 0, "R10 priority");
        step(1, 1, 16, 0, 0, 0, 0, 0, S_IN, 1, 0, "R11 to in");
        step(0, 0, 0, 0, 0, 0, 0, 1, S_HALT, 0, 0, "R10 from in");
        step(1, 0, 0, 0, 0, 0, 0, 0, S_IDLE, 0, 1, "R11 nodata");
        step(0, 0, 0, 0, 0, 0, 0, 1, S_HALT, 0, 0, "R10 from idle");
        step(1, 0, 0, 0, 0, 0, 0, 0, S_IDLE, 0, 1, "R11 back");
        idle(S_IDLE, "R12 end");
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d pending results, expected 0", expq.size());
        end
        finish_run();
    end
endmodule